// File: doc/BRIEF.md
# Message buffer interrupt flag unit

This block holds one completion flag and one interrupt-enable bit for each of up to `NUM_BUF` message buffers. A buffer's flag goes high when that buffer reports a finished transfer. The transfer may be a transmission or a reception; both use the same flag. Software clears a flag by writing a one to its bit position. Software reads the flags and the enables back through plain output vectors.

Each buffer has its own interrupt line, which is high when both its flag and its enable are set. Six combined lines sit beside the per-buffer lines:

- the OR of all buffer lines,
- registered copies of five status conditions coming from elsewhere: bus-off, error, transmit warning, receive warning and wake-up.

A configured buffer count limits which buffers are active. Positions at or above that count keep their flags, enables and interrupt lines at zero.

Top module: `mb_irq_unit`

## Requirements
- R1: After the asynchronous reset `rst_ni` low, all flags, enables, buffer lines and combined lines read zero.
- R2: A high `done_i[i]` at a clock edge sets `flag_o[i]` at that edge. This holds only for an active buffer `i`. There is one flag per buffer for both directions.
- R3: A write with `reg_we_i=1` and `reg_sel_i=0` clears every flag whose `reg_wdata_i` bit is 1. Flags whose `reg_wdata_i` bit is 0 keep their value.
- R4: When `done_i[i]` and a clearing write to bit `i` fall in the same cycle, `flag_o[i]` ends up set.
- R5: A write with `reg_we_i=1` and `reg_sel_i=1` loads the enable vector `mask_o` from `reg_wdata_i`. Without such a write, the enables hold their value.
- R6: `buf_irq_o[i]` equals `flag_o[i] & mask_o[i]`. It changes at the same edge as the flag and enable registers.
- R7: `sum_irq_o[0]` is the OR of all `buf_irq_o` bits, updated at the same edge.
- R8: The status inputs appear on `sum_irq_o` one clock edge after they are sampled. The bit positions are: bit 1 bus-off, bit 2 error, bit 3 transmit warning, bit 4 receive warning, bit 5 wake-up. Each output stays high as long as its input stays high.
- R9: Buffer `i` is active only when `i < buf_cnt_i`. For an inactive index, `done_i` and register writes are ignored, and the flag, enable and buffer line are zero from the next edge onward.
- R10: A `buf_cnt_i` value of `NUM_BUF` or more makes every buffer active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | NUM_BUF | Per-buffer transfer-complete pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 flags (write one to clear), 1 enables |
| reg_wdata_i | input | NUM_BUF | Register write data |
| buf_cnt_i | input | CNT_W | Number of active buffers |
| bus_off_i | input | 1 | Bus-off condition |
| err_i | input | 1 | Error condition |
| tx_warn_i | input | 1 | Transmit warning condition |
| rx_warn_i | input | 1 | Receive warning condition |
| wake_i | input | 1 | Wake-up condition |
| flag_o | output | NUM_BUF | Current flag values (read path) |
| mask_o | output | NUM_BUF | Current enable values (read path) |
| buf_irq_o | output | NUM_BUF | Per-buffer interrupt lines |
| sum_irq_o | output | 6 | Combined interrupt lines |

## Verification
Random cycles drive sparse completions, clear writes with random data, enable writes, toggling status conditions and a changing buffer count. Together these separate set from clear, and enable gating from flag state. Directed cases pin down the following:
- a clear write of zeros, which must leave the flags untouched;
- a completion that collides with a clear, which tells "set wins" apart from "clear wins";
- count values of zero, a middle value and one above the buffer total, which separate the active-index cut from an off-by-one and check that the top count saturates.

// File: rtl/mb_irq_pkg.sv
package mb_irq_pkg;
  localparam int unsigned SUM_W = 6;

  typedef enum int unsigned {
    SUM_BUF     = 0,
    SUM_BUS_OFF = 1,
    SUM_ERR     = 2,
    SUM_TX_WARN = 3,
    SUM_RX_WARN = 4,
    SUM_WAKE    = 5
  } sum_idx_e;

  typedef enum logic {
    SEL_FLAG = 1'b0,
    SEL_MASK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/mb_irq_valid.sv
module mb_irq_valid #(
  parameter int unsigned NUM_BUF = 32,
  localparam int unsigned CNT_W = $clog2(NUM_BUF + 1)
) (
  input  logic [CNT_W-1:0]   buf_cnt_i,
  output logic [NUM_BUF-1:0] valid_o
);
  // thermometer: index i active when below count; counts >= NUM_BUF saturate
  for (genvar i = 0; i < NUM_BUF; i++) begin : g_valid
    assign valid_o[i] = (buf_cnt_i > CNT_W'(i));
  end
endmodule

// File: rtl/mb_irq_flag_bank.sv
module mb_irq_flag_bank
  import mb_irq_pkg::*;
#(
  parameter int unsigned NUM_BUF = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_BUF-1:0] valid_i,
  input  logic [NUM_BUF-1:0] done_i,
  input  logic               reg_we_i,
  input  logic               reg_sel_i,
  input  logic [NUM_BUF-1:0] reg_wdata_i,
  output logic [NUM_BUF-1:0] flag_q_o,
  output logic [NUM_BUF-1:0] mask_q_o,
  output logic [NUM_BUF-1:0] flag_d_o,
  output logic [NUM_BUF-1:0] mask_d_o
);
  logic wr_flag, wr_mask;
  assign wr_flag = reg_we_i && (reg_sel_e'(reg_sel_i) == SEL_FLAG);
  assign wr_mask = reg_we_i && (reg_sel_e'(reg_sel_i) == SEL_MASK);

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_bit
    logic clr;
    assign clr = wr_flag && reg_wdata_i[i];
    // new completion dominates a same-cycle clear
    assign flag_d_o[i] = valid_i[i] && (done_i[i] || (flag_q_o[i] && !clr));
    assign mask_d_o[i] = valid_i[i] && (wr_mask ? reg_wdata_i[i] : mask_q_o[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q_o[i] <= 1'b0;
        mask_q_o[i] <= 1'b0;
      end else begin
        flag_q_o[i] <= flag_d_o[i];
        mask_q_o[i] <= mask_d_o[i];
      end
    end
  end
endmodule

// File: rtl/mb_irq_combine.sv
module mb_irq_combine
  import mb_irq_pkg::*;
#(
  parameter int unsigned NUM_BUF = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_BUF-1:0] flag_d_i,
  input  logic [NUM_BUF-1:0] mask_d_i,
  input  logic               bus_off_i,
  input  logic               err_i,
  input  logic               tx_warn_i,
  input  logic               rx_warn_i,
  input  logic               wake_i,
  output logic [NUM_BUF-1:0] buf_irq_o,
  output logic [SUM_W-1:0]   sum_irq_o
);
  logic [NUM_BUF-1:0] irq_d;
  logic [SUM_W-1:0]   sum_d;

  // irq computed from next-state so lines align with the flag registers
  assign irq_d = flag_d_i & mask_d_i;

  always_comb begin
    sum_d              = '0;
    sum_d[SUM_BUF]     = |irq_d;
    sum_d[SUM_BUS_OFF] = bus_off_i;
    sum_d[SUM_ERR]     = err_i;
    sum_d[SUM_TX_WARN] = tx_warn_i;
    sum_d[SUM_RX_WARN] = rx_warn_i;
    sum_d[SUM_WAKE]    = wake_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_irq_o <= '0;
      sum_irq_o <= '0;
    end else begin
      buf_irq_o <= irq_d;
      sum_irq_o <= sum_d;
    end
  end
endmodule

// File: rtl/mb_irq_unit.sv
module mb_irq_unit
  import mb_irq_pkg::*;
#(
  parameter int unsigned NUM_BUF = 32,
  localparam int unsigned CNT_W = $clog2(NUM_BUF + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_BUF-1:0] done_i,
  input  logic               reg_we_i,
  input  logic               reg_sel_i,
  input  logic [NUM_BUF-1:0] reg_wdata_i,
  input  logic [CNT_W-1:0]   buf_cnt_i,
  input  logic               bus_off_i,
  input  logic               err_i,
  input  logic               tx_warn_i,
  input  logic               rx_warn_i,
  input  logic               wake_i,
  output logic [NUM_BUF-1:0] flag_o,
  output logic [NUM_BUF-1:0] mask_o,
  output logic [NUM_BUF-1:0] buf_irq_o,
  output logic [SUM_W-1:0]   sum_irq_o
);
  logic [NUM_BUF-1:0] valid, flag_d, mask_d;

  mb_irq_valid #(.NUM_BUF(NUM_BUF)) u_valid (
    .buf_cnt_i (buf_cnt_i),
    .valid_o   (valid)
  );

  mb_irq_flag_bank #(.NUM_BUF(NUM_BUF)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid),
    .done_i      (done_i),
    .reg_we_i    (reg_we_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wdata_i (reg_wdata_i),
    .flag_q_o    (flag_o),
    .mask_q_o    (mask_o),
    .flag_d_o    (flag_d),
    .mask_d_o    (mask_d)
  );

  mb_irq_combine #(.NUM_BUF(NUM_BUF)) u_comb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flag_d_i  (flag_d),
    .mask_d_i  (mask_d),
    .bus_off_i (bus_off_i),
    .err_i     (err_i),
    .tx_warn_i (tx_warn_i),
    .rx_warn_i (rx_warn_i),
    .wake_i    (wake_i),
    .buf_irq_o (buf_irq_o),
    .sum_irq_o (sum_irq_o)
  );
endmodule

// File: rtl/mb_irq_unit_chk.sv
module mb_irq_unit_chk #(
  parameter int unsigned NUM_BUF = 32,
  localparam int unsigned CNT_W = $clog2(NUM_BUF + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_BUF-1:0] done_i,
  input logic               reg_we_i,
  input logic               reg_sel_i,
  input logic [NUM_BUF-1:0] reg_wdata_i,
  input logic [CNT_W-1:0]   buf_cnt_i,
  input logic               bus_off_i,
  input logic               err_i,
  input logic               tx_warn_i,
  input logic               rx_warn_i,
  input logic               wake_i,
  input logic [NUM_BUF-1:0] flag_o,
  input logic [NUM_BUF-1:0] mask_o,
  input logic [NUM_BUF-1:0] buf_irq_o,
  input logic [5:0]         sum_irq_o
);
  logic [NUM_BUF-1:0] act;
  always_comb begin
    for (int i = 0; i < NUM_BUF; i++) act[i] = (int'(buf_cnt_i) > i);
  end

  assert_done_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(done_i & act) |=> ((flag_o & $past(done_i & act)) == $past(done_i & act)));

  assert_w1c_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_sel_i) |=> ((flag_o & $past(reg_wdata_i & ~done_i)) == '0));

  assert_mask_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i) |=> (mask_o == $past(reg_wdata_i & act)));

  assert_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_irq_o == (flag_o & mask_o));

  assert_or_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_irq_o[0] == (|buf_irq_o));

  assert_status_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sum_irq_o[5:1] == $past({wake_i, rx_warn_i, tx_warn_i, err_i, bus_off_i})));

  assert_inactive_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((flag_o | mask_o | buf_irq_o) & ~$past(act)) == '0));
endmodule

bind mb_irq_unit mb_irq_unit_chk #(.NUM_BUF(NUM_BUF)) u_chk (.*);

// File: tb/mb_irq_unit_tb.sv
module mb_irq_unit_tb;
  localparam int unsigned NB = 32;
  localparam int unsigned CW = $clog2(NB + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NB-1:0] done, wdata;
  logic we, sel;
  logic [CW-1:0] cnt;
  logic bo, er, tw, rw, wk;
  logic [NB-1:0] flag_o, mask_o, irq_o;
  logic [5:0] sum_o;

  always #10 clk = ~clk;  // 50 MHz

  mb_irq_unit #(.NUM_BUF(NB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .done_i(done), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .buf_cnt_i(cnt), .bus_off_i(bo), .err_i(er),
    .tx_warn_i(tw), .rx_warn_i(rw), .wake_i(wk),
    .flag_o(flag_o), .mask_o(mask_o), .buf_irq_o(irq_o), .sum_irq_o(sum_o)
  );

  int checks = 0, fails = 0;
  bit done_flag = 0;
  logic [NB-1:0] m_flag = '0, m_mask = '0;
  logic [4:0] m_stat = '0;

  function automatic logic [NB-1:0] act_of(input logic [CW-1:0] c);
    logic [NB-1:0] v;
    for (int i = 0; i < NB; i++) v[i] = (int'(c) > i);
    return v;
  endfunction

  task automatic chk(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [NB-1:0] e_irq;
    e_irq = m_flag & m_mask;
    chk({tag, " R2 flags"}, flag_o, m_flag);
    chk({tag, " R5 mask"}, mask_o, m_mask);
    chk({tag, " R6 irq"}, irq_o, e_irq);
    chk({tag, " R7 or"}, NB'(sum_o[0]), NB'(|e_irq));
    chk({tag, " R8 status"}, NB'(sum_o[5:1]), NB'(m_stat));
  endtask

  // inputs set at negedge; model advanced; outputs checked at following negedge
  task automatic step(input string tag);
    logic [NB-1:0] v, clr;
    v = act_of(cnt);
    clr = (we && !sel) ? wdata : '0;
    m_flag = v & (done | (m_flag & ~clr));
    m_mask = v & ((we && sel) ? wdata : m_mask);
    m_stat = {wk, rw, tw, er, bo};
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle();
    done = '0; we = 0; sel = 0; wdata = '0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    idle(); cnt = CW'(NB); {bo, er, tw, rw, wk} = '0;
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1;
    @(negedge clk);

    // R5 enable all, R2 set flags
    we = 1; sel = 1; wdata = '1; step("R5 load");
    idle(); done = 32'h0000_8001; step("R2 set");
    idle(); we = 1; sel = 0; wdata = '0; step("R3 write zero keeps");
    idle(); we = 1; sel = 0; wdata = 32'h0000_0001; step("R3 clear one");
    chk("R3 bit15 kept", NB'(flag_o[15]), NB'(1));
    // R4 completion wins over clear
    idle(); we = 1; sel = 0; wdata = 32'h0000_8000; done = 32'h0000_8000; step("R4 collide");
    chk("R4 flag15 set", NB'(flag_o[15]), NB'(1));
    // R9 inactive index ignored
    idle(); cnt = CW'(8); done = 32'hFFFF_FFFF; step("R9 cnt8");
    chk("R9 upper flags zero", flag_o & ~32'hFF, '0);
    idle(); cnt = '0; done = '1; we = 0; step("R9 cnt0");
    chk("R9 none active", flag_o | mask_o | irq_o, '0);
    // R10 count above total saturates
    idle(); cnt = CW'(NB + 8); we = 1; sel = 1; wdata = '1; step("R10 load");
    idle(); done = 32'h8000_0000; step("R10 top bit");
    chk("R10 bit31 irq", NB'(irq_o[31]), NB'(1));
    // R8 status levels
    idle(); {bo, er, tw, rw, wk} = 5'b10101; step("R8 pattern a");
    {bo, er, tw, rw, wk} = 5'b01010; step("R8 pattern b");
    {bo, er, tw, rw, wk} = 5'b00000; step("R8 clear");

    for (int n = 0; n < 600; n++) begin
      done  = $urandom() & $urandom() & $urandom();
      we    = ($urandom() % 3) == 0;
      sel   = $urandom() % 2;
      wdata = $urandom();
      if ((n % 50) == 0) cnt = CW'($urandom() % (NB + 10));
      {bo, er, tw, rw, wk} = 5'($urandom());
      step("rand R2 R3 R4 R5 R9");
    end
    finish_run();
  end
endmodule